// File: doc/BRIEF.md
# Multi-Wavefront Round-Robin Issue Scheduler

This block chooses, for one 16-lane SIMD, which resident wavefronts issue in the current cycle. The SIMD holds up to ten wavefront slots. For each slot the front end presents four things: whether the slot is occupied, whether an outside condition (a barrier wait or a memory dependency) holds it back, the class code of its next instruction, and an argument field. The slot also reports its count of outstanding vector-memory operations.

Five functional-unit classes are arbitrated independently: vector ALU, scalar (scalar ALU, scalar memory read, branch and message), vector memory, local-share and export/global-share. Each class has its own round-robin pointer, so a single cycle can issue up to five instructions, each to a different wavefront. Special instructions need no unit. Plain specials (no-op, sleep, barrier marker, priority change) and count waits are retired inside the scheduler by a sixth round-robin arbiter. A count wait retires only once the slot's outstanding vector-memory count has dropped to its immediate value or below. A vector ALU issue occupies the SIMD for 4, 8 or 16 clocks, and no other vector ALU issue is granted during that time.

Grants are combinational from the current slot inputs and the registered arbiter state. Grants become visible in the same cycle, and the pointers and busy timer update at the next clock edge. Since each slot offers only its single next instruction, a wavefront issues in program order and never receives two grants in one cycle.

Top module: `wsched_top`

## Requirements
- R1: After reset every arbiter starts searching at slot 0, so when all slots request the same class the first grant goes to slot 0. While no slot is occupied, no grant and no retire is given.
- R2: A slot whose occupied bit is 0 or whose hold bit is 1 receives no unit grant and no retire.
- R3: Each unit class (op codes 0 vector ALU, 1 scalar, 2 vector memory, 3 local share, 4 export) grants at most one slot per cycle. Its grant vector is one-hot or zero, and its ID output equals the position of the set bit.
- R4: A class grants the first requesting slot at or after its pointer, wrapping from slot 9 to slot 0. After a grant the pointer moves to the slot just after the granted one.
- R5: A slot receives at most one grant or retire in a cycle, across all unit classes and the retire path.
- R6: Different classes grant in the same cycle to different slots, so up to five unit grants and one retire can occur together.
- R7: A vector ALU grant blocks further vector ALU grants for a span set by bits [1:0] of the granted slot's argument: code 0 gives 4 cycles, code 1 gives 8 cycles, and codes 2 and 3 give 16 cycles. The next vector ALU grant comes no earlier than that many cycles after the previous one.
- R8: Op code 5 (plain special) produces no unit grant. It is retired through the retire vector, with one retire per cycle chosen in round-robin order.
- R9: Op code 6 (count wait) retires only while the slot's outstanding vector-memory count is at or below the slot's argument. Until then the slot is passed over. Op code 7 means no instruction is ready.
- R10: A slot that keeps requesting a class is granted within ten grants of that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_slot_valid | input | NUM_SLOTS | Slot holds a resident wavefront |
| i_slot_stall | input | NUM_SLOTS | Slot held back by an outside condition |
| i_slot_op | input | 3*NUM_SLOTS | Next-instruction class code per slot |
| i_slot_arg | input | CNT_W*NUM_SLOTS | Latency code (vector ALU) or count threshold (count wait) |
| i_slot_vmcnt | input | CNT_W*NUM_SLOTS | Outstanding vector-memory operations per slot |
| o_unit_gnt | output | 5*NUM_SLOTS | One-hot grant vector per unit class |
| o_unit_id | output | 5*IDW | Granted slot ID per unit class |
| o_unit_vld | output | 5 | A grant exists for the class |
| o_retire | output | NUM_SLOTS | Special instruction retired in the scheduler |

## Verification
On every cycle the assertions check that the grant vectors are one-hot or zero and that they go only to occupied, unheld slots. They also check that no slot collects two grants, that count waits retire only once their threshold is met, that vector ALU grants keep their busy spacing, and that a continuously requesting slot waits behind at most nine grants of its class. The exact choice made by round-robin order, where the pointer wraps, the measured spans for each latency code, and several classes issuing together can only be shown by the bench's scenarios. The bench compares every output, every cycle, against an arithmetic model built from the requirements.

// File: rtl/wsched_pkg.sv
`timescale 1ns/1ps
package wsched_pkg;
    localparam int OP_W      = 3;
    localparam int NUM_UNITS = 5;

    typedef enum logic [OP_W-1:0] {
        OP_VALU   = 3'd0,
        OP_SCALAR = 3'd1,
        OP_VMEM   = 3'd2,
        OP_LDS    = 3'd3,
        OP_EXPORT = 3'd4,
        OP_SPEC   = 3'd5,
        OP_WAIT   = 3'd6,
        OP_IDLE   = 3'd7
    } op_e;
endpackage

// File: rtl/wsched_rr_pick.sv
`timescale 1ns/1ps
module wsched_rr_pick #(
    parameter int N   = 10,
    parameter int IDW = 4
) (
    input  logic [N-1:0]   req,
    input  logic [IDW-1:0] ptr,
    output logic [N-1:0]   gnt,
    output logic [IDW-1:0] gnt_id,
    output logic           found
);
    always_comb begin
        gnt    = '0;
        gnt_id = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                gnt_id   = IDW'(idx);
            end
        end
    end
endmodule

// File: rtl/wsched_valu_timer.sv
`timescale 1ns/1ps
module wsched_valu_timer #(
    parameter int BASE_LAT = 4,
    parameter int TW       = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] lat_code,
    output logic       busy
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    int      span;

    always_comb begin
        st_d = st_q;
        span = (lat_code >= 2'd2) ? BASE_LAT * 4 : BASE_LAT << lat_code;
        if (start) begin
            st_d.cnt = TW'(span - 1);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/wsched_top.sv
`timescale 1ns/1ps
module wsched_top
    import wsched_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int CNT_W     = 4,
    parameter int BASE_LAT  = 4,
    localparam int IDW      = $clog2(NUM_SLOTS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SLOTS-1:0]      i_slot_valid,
    input  logic [NUM_SLOTS-1:0]      i_slot_stall,
    input  logic [OP_W*NUM_SLOTS-1:0] i_slot_op,
    input  logic [CNT_W*NUM_SLOTS-1:0] i_slot_arg,
    input  logic [CNT_W*NUM_SLOTS-1:0] i_slot_vmcnt,
    output logic [NUM_UNITS*NUM_SLOTS-1:0] o_unit_gnt,
    output logic [NUM_UNITS*IDW-1:0]  o_unit_id,
    output logic [NUM_UNITS-1:0]      o_unit_vld,
    output logic [NUM_SLOTS-1:0]      o_retire
);
    localparam int NUM_ARB = NUM_UNITS + 1;
    localparam int SPEC_IX = NUM_UNITS;
    localparam int TW      = $clog2(BASE_LAT * 4);

    typedef struct packed {
        logic [NUM_ARB-1:0][IDW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    logic [NUM_ARB-1:0][NUM_SLOTS-1:0] req;
    logic [NUM_ARB-1:0][NUM_SLOTS-1:0] gnt;
    logic [NUM_ARB-1:0][IDW-1:0]       gid;
    logic [NUM_ARB-1:0]                found;
    logic                              valu_busy;
    logic [1:0]                        valu_lat;

    // Eligibility per arbiter and slot
    always_comb begin
        req = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            logic             live;
            op_e              op;
            logic [CNT_W-1:0] arg;
            logic [CNT_W-1:0] vmc;
            live = i_slot_valid[s] && !i_slot_stall[s];
            op   = op_e'(i_slot_op[s*OP_W +: OP_W]);
            arg  = i_slot_arg[s*CNT_W +: CNT_W];
            vmc  = i_slot_vmcnt[s*CNT_W +: CNT_W];
            for (int a = 0; a < NUM_UNITS; a++) begin
                req[a][s] = live && (op == op_e'(a));
            end
            req[0][s] = req[0][s] && !valu_busy;
            req[SPEC_IX][s] = live && ((op == OP_SPEC) ||
                                       ((op == OP_WAIT) && (vmc <= arg)));
        end
    end

    for (genvar a = 0; a < NUM_ARB; a++) begin : g_arb
        wsched_rr_pick #(.N(NUM_SLOTS), .IDW(IDW)) u_pick (
            .req    (req[a]),
            .ptr    (st_q.ptr[a]),
            .gnt    (gnt[a]),
            .gnt_id (gid[a]),
            .found  (found[a])
        );
    end

    // Latency code of the vector ALU instruction being granted
    always_comb begin
        valu_lat = 2'd0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (gnt[0][s]) valu_lat = i_slot_arg[s*CNT_W +: 2];
        end
    end

    wsched_valu_timer #(.BASE_LAT(BASE_LAT), .TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (found[0]),
        .lat_code (valu_lat),
        .busy     (valu_busy)
    );

    // Pointer advance: one past the granted slot, wrapping
    always_comb begin
        st_d = st_q;
        for (int a = 0; a < NUM_ARB; a++) begin
            if (found[a]) begin
                st_d.ptr[a] = (gid[a] == IDW'(NUM_SLOTS - 1)) ? '0 : gid[a] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar a = 0; a < NUM_UNITS; a++) begin : g_out
        assign o_unit_gnt[a*NUM_SLOTS +: NUM_SLOTS] = gnt[a];
        assign o_unit_id[a*IDW +: IDW]              = gid[a];
        assign o_unit_vld[a]                        = found[a];
    end
    assign o_retire = gnt[SPEC_IX];
endmodule

// File: rtl/wsched_chk.sv
`timescale 1ns/1ps
module wsched_chk
    import wsched_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int CNT_W     = 4,
    parameter int BASE_LAT  = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_SLOTS-1:0]           i_slot_valid,
    input logic [NUM_SLOTS-1:0]           i_slot_stall,
    input logic [OP_W*NUM_SLOTS-1:0]      i_slot_op,
    input logic [CNT_W*NUM_SLOTS-1:0]     i_slot_arg,
    input logic [CNT_W*NUM_SLOTS-1:0]     i_slot_vmcnt,
    input logic [NUM_UNITS*NUM_SLOTS-1:0] o_unit_gnt,
    input logic [NUM_UNITS-1:0]           o_unit_vld,
    input logic [NUM_SLOTS-1:0]           o_retire
);
    localparam int WW = $clog2(NUM_SLOTS) + 1;

    logic [NUM_SLOTS-1:0][NUM_UNITS:0] per_slot;
    logic [NUM_SLOTS-1:0]              any_hit;
    int                                lat_now;
    logic [6:0]                        since_q;
    logic [5:0]                        need_q;
    logic [NUM_SLOTS-1:0][WW-1:0]      wait_q;

    always_comb begin
        lat_now = 0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            for (int a = 0; a < NUM_UNITS; a++) per_slot[s][a] = o_unit_gnt[a*NUM_SLOTS + s];
            per_slot[s][NUM_UNITS] = o_retire[s];
            any_hit[s] = |per_slot[s];
            if (o_unit_gnt[s]) begin
                lat_now = (i_slot_arg[s*CNT_W +: 2] >= 2'd2) ? BASE_LAT * 4
                        : BASE_LAT << i_slot_arg[s*CNT_W +: 2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            need_q  <= '0;
        end else if (o_unit_vld[0]) begin
            since_q <= 7'd1;
            need_q  <= 6'(lat_now);
        end else if (since_q != 7'h7f) begin
            since_q <= since_q + 1'b1;
        end
    end

    for (genvar a = 0; a < NUM_UNITS; a++) begin : g_unit
        // R3
        onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(o_unit_gnt[a*NUM_SLOTS +: NUM_SLOTS]) &&
            (o_unit_vld[a] == (o_unit_gnt[a*NUM_SLOTS +: NUM_SLOTS] != '0)));
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic vreq;
        assign vreq = i_slot_valid[s] && !i_slot_stall[s] &&
                      (i_slot_op[s*OP_W +: OP_W] == OP_VALU);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           wait_q[s] <= '0;
            else if (!vreq || o_unit_gnt[s])      wait_q[s] <= '0;
            else if (o_unit_vld[0])               wait_q[s] <= wait_q[s] + 1'b1;
        end

        // R2
        runnable_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            any_hit[s] |-> (i_slot_valid[s] && !i_slot_stall[s]));
        // R5
        single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(per_slot[s]) <= 1);
        // R8
        retire_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
            o_retire[s] |-> ((i_slot_op[s*OP_W +: OP_W] == OP_SPEC) ||
                             (i_slot_op[s*OP_W +: OP_W] == OP_WAIT)));
        // R9
        wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (o_retire[s] && (i_slot_op[s*OP_W +: OP_W] == OP_WAIT)) |->
            (i_slot_vmcnt[s*CNT_W +: CNT_W] <= i_slot_arg[s*CNT_W +: CNT_W]));
        // R10
        fair_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q[s] <= WW'(NUM_SLOTS - 1));
    end

    // R7
    valu_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_unit_vld[0] |-> (since_q >= 7'(need_q)));
endmodule

bind wsched_top wsched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CNT_W     (CNT_W),
    .BASE_LAT  (BASE_LAT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_slot_valid (i_slot_valid),
    .i_slot_stall (i_slot_stall),
    .i_slot_op    (i_slot_op),
    .i_slot_arg   (i_slot_arg),
    .i_slot_vmcnt (i_slot_vmcnt),
    .o_unit_gnt   (o_unit_gnt),
    .o_unit_vld   (o_unit_vld),
    .o_retire     (o_retire)
);

// File: tb/wsched_top_test.sv
`timescale 1ns/1ps
module wsched_top_test;
    localparam int N   = 10;
    localparam int CW  = 4;
    localparam int IDW = 4;
    localparam int NU  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    b_valid = '0;
    logic [N-1:0]    b_stall = '0;
    logic [3*N-1:0]  b_op    = '1;
    logic [CW*N-1:0] b_arg   = '0;
    logic [CW*N-1:0] b_vm    = '0;
    logic [NU*N-1:0] o_unit_gnt;
    logic [NU*IDW-1:0] o_unit_id;
    logic [NU-1:0]   o_unit_vld;
    logic [N-1:0]    o_retire;

    int total = 0;
    int bad   = 0;
    int m_ptr [6];
    int m_busy;
    int e_id  [6];
    int a_id  [6];
    int rnd   = 32'h1234abcd;

    always #4 clk = ~clk;

    wsched_top uut (
        .clk(clk), .rst_n(rst_n),
        .i_slot_valid(b_valid), .i_slot_stall(b_stall), .i_slot_op(b_op),
        .i_slot_arg(b_arg), .i_slot_vmcnt(b_vm),
        .o_unit_gnt(o_unit_gnt), .o_unit_id(o_unit_id),
        .o_unit_vld(o_unit_vld), .o_retire(o_retire)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_rnd();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >>> 17);
        rnd = rnd ^ (rnd << 5);
        return rnd & 32'h7fffffff;
    endfunction

    task automatic set_slot(input int s, input int v, input int st, input int op,
                            input int arg, input int vm);
        b_valid[s] = v[0];
        b_stall[s] = st[0];
        b_op[s*3 +: 3]   = 3'(op);
        b_arg[s*CW +: CW] = CW'(arg);
        b_vm[s*CW +: CW]  = CW'(vm);
    endtask

    task automatic clear_all();
        for (int s = 0; s < N; s++) set_slot(s, 0, 0, 7, 0, 0);
    endtask

    function automatic bit m_req(input int a, input int s);
        int op;
        bit live;
        live = b_valid[s] && !b_stall[s];
        op   = int'(b_op[s*3 +: 3]);
        if (!live) return 0;
        if (a == 0) return (op == 0) && (m_busy == 0);
        if (a < NU) return op == a;
        return (op == 5) || ((op == 6) && (b_vm[s*CW +: CW] <= b_arg[s*CW +: CW]));
    endfunction

    function automatic int m_pick(input int a);
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (m_ptr[a] + k) % N;
            if (m_req(a, idx)) return idx;
        end
        return -1;
    endfunction

    // One cycle: compare all outputs to the model, then advance on the edge.
    task automatic cyc();
        int hits;
        #1;
        for (int a = 0; a < 6; a++) e_id[a] = m_pick(a);
        for (int a = 0; a < NU; a++) begin
            logic [N-1:0] v;
            v = o_unit_gnt[a*N +: N];
            a_id[a] = o_unit_vld[a] ? int'(o_unit_id[a*IDW +: IDW]) : -1;
            // R3: vector equals one-hot of the reported ID
            check("R3 vector", int'(v), (a_id[a] >= 0) ? (1 << a_id[a]) : 0);
            check((a == 0) ? "R7 valu pick" : "R4 unit pick", a_id[a], e_id[a]);
        end
        a_id[5] = -1;
        for (int s = 0; s < N; s++) if (o_retire[s]) a_id[5] = s;
        check("R8 retire count", $countones(o_retire), (e_id[5] >= 0) ? 1 : 0);
        check("R8 retire pick", a_id[5], e_id[5]);
        for (int s = 0; s < N; s++) begin
            hits = int'(o_retire[s]);
            for (int a = 0; a < NU; a++) hits += int'(o_unit_gnt[a*N + s]);
            if (hits > 1) check("R5 one per slot", hits, 1);
        end
        @(posedge clk);
        for (int a = 0; a < 6; a++) if (e_id[a] >= 0) m_ptr[a] = (e_id[a] + 1) % N;
        if (e_id[0] >= 0) begin
            int c;
            c = int'(b_arg[e_id[0]*CW +: 2]);
            m_busy = ((c >= 2) ? 16 : (4 << c)) - 1;
        end else if (m_busy > 0) begin
            m_busy--;
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 6; a++) m_ptr[a] = 0;
        m_busy = 0;
        clear_all();
        repeat (3) @(negedge clk);
        // R1: no occupied slot, nothing granted
        check("R1 idle vld", int'(o_unit_vld), 0);
        check("R1 idle retire", int'(o_retire), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R4 / R10: all slots scalar, grants rotate 0..9 and wrap
        for (int s = 0; s < N; s++) set_slot(s, 1, 0, 1, 0, 0);
        for (int k = 0; k < 12; k++) begin
            cyc();
            check((k == 0) ? "R1 first slot" : "R10 rotation", a_id[1], k % N);
        end

        // R2: held or empty slots get nothing
        for (int s = 0; s < N; s++) set_slot(s, s % 2, (s % 2 == 1) ? 1 : 0, s % 7, 0, 0);
        cyc();
        for (int a = 0; a < 6; a++) check("R2 held slots", a_id[a], -1);

        // R6: five units plus a retire in one cycle
        clear_all();
        for (int s = 0; s < 6; s++) set_slot(s, 1, 0, s, 0, 0);
        cyc();
        for (int a = 0; a < 6; a++) check("R6 parallel issue", a_id[a], a);

        // R7: spacing between vector ALU grants per latency code
        for (int c = 0; c < 4; c++) begin
            int first;
            int second;
            clear_all();
            repeat (20) cyc();
            set_slot(3, 1, 0, 0, c, 0);
            first  = -1;
            second = -1;
            for (int k = 0; k < 40; k++) begin
                cyc();
                if (a_id[0] == 3) begin
                    if (first < 0) first = k;
                    else if (second < 0) second = k;
                end
            end
            check("R7 span", second - first, (c >= 2) ? 16 : (4 << c));
        end

        // R8 / R9: count wait held while plain special retires
        clear_all();
        set_slot(2, 1, 0, 6, 3, 5);
        set_slot(7, 1, 0, 5, 0, 0);
        cyc();
        check("R8 special retired", a_id[5], 7);
        check("R8 no unit grant", int'(o_unit_vld), 0);
        set_slot(7, 0, 0, 7, 0, 0);
        for (int v = 5; v >= 0; v--) begin
            b_vm[2*CW +: CW] = CW'(v);
            cyc();
            check("R9 wait threshold", a_id[5], (v <= 3) ? 2 : -1);
        end

        // Sweep: pseudo-random slot contents, model comparison each cycle
        for (int k = 0; k < 3000; k++) begin
            for (int s = 0; s < N; s++) begin
                int r;
                r = next_rnd();
                set_slot(s, (r & 7) != 0, ((r >> 3) & 3) == 0, (r >> 5) & 7,
                         (r >> 8) & 15, (r >> 12) & 15);
            end
            cyc();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule